// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block holds a 256-bit device secret as eight 32-bit words and exposes it on a memory-mapped bus. A word is returned only the first time it is read after power-on, and only while the device is in its privileged loader mode. Once a word has been handed out, every later read of that word returns zero until the next power-on reset. When the mode input signals that untrusted application code is running, the whole region reads as zero and no word is marked as consumed.

The bus is a simple strobe interface: a one-cycle strobe with a write flag and a 32-bit byte address. The region answers only when the top byte of the address equals the core-select value 0xC2. Read data appears on the cycle after the strobe. Writes are accepted and discarded. The secret value is a parameter, so provisioning is outside this block.

Top module: `secret_vault`

## Requirements
- R1: After reset, `bus_rdata` is 0 and all eight words are unread.
- R2: A read strobe in loader mode (`app_mode`=0) to address 0xC2000000 + 4*k (k = 0..7) of a word not yet read returns `SECRET[32*k+31:32*k]` on `bus_rdata` in the cycle after the strobe.
- R3: Any later read of a word that has already been returned gives 0, including a read on the very next cycle.
- R4: Each word has its own read flag; reading word k does not change what a first read of any other word returns.
- R5: While `app_mode`=1 every read returns 0 and marks no word as read; a word read in that state is still returned on a later first read in loader mode.
- R6: A write strobe (`bus_we`=1) returns 0 in the next cycle and marks no word as read, in either mode.
- R7: A read is ignored (returns 0, marks nothing) when `bus_addr[1:0]` is nonzero, when `bus_addr[23:5]` is nonzero (beyond the eighth word), or when `bus_addr[31:24]` is not 0xC2.
- R8: `bus_rdata` is 0 in every cycle that does not follow a strobe that returns a secret word.
- R9: Only reset clears the read flags; after a reset every word can be read once again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| app_mode | input | 1 | 1 while application code runs; hides the secret |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 32 | Byte address; top byte is the core select |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |

## Verification
The hard case is proving that an access which must be ignored leaves the hidden per-word flags untouched, since they are not visible at the ports. The bench brings that state out by following every ignored access (application-mode read, write, misaligned, out-of-range or foreign-core read) with a first loader-mode read of the same word and expecting the secret. Back-to-back reads of one word check that the flag set by the first strobe already suppresses the second, and a mid-run reset shows the flags only clear there.

// File: rtl/vault_pkg.sv
// Shared constants and types for the read-once secret store.
// Assumes 32-bit words and byte addressing with word alignment.
package vault_pkg;
    localparam int WORD_W  = 32;
    localparam int ALIGN_W = 2;
    localparam int SEL_W   = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/vault_decode.sv
// Address decoder: classifies a bus strobe and checks that the address
// falls on this core, is word aligned and lies inside the word window.
// Assumes the core select sits in the top SEL_W bits of the address.
module vault_decode
    import vault_pkg::*;
#(
    parameter int             ADDR_W  = 32,
    parameter int             N_WORDS = 8,
    parameter logic [SEL_W-1:0] CORE_ID = 8'hC2,
    localparam int            IDX_W   = $clog2(N_WORDS)
) (
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic              in_window,
    output logic [IDX_W-1:0]  idx
);
    logic core_hit;
    logic aligned;
    logic in_range;

    // Purpose: split the address into its select, offset and alignment parts.
    always_comb begin
        core_hit  = (addr[ADDR_W-1 -: SEL_W] == CORE_ID);
        aligned   = (addr[ALIGN_W-1:0] == '0);
        in_range  = (addr[ADDR_W-SEL_W-1:IDX_W+ALIGN_W] == '0);
        in_window = core_hit && aligned && in_range;
        idx       = addr[IDX_W+ALIGN_W-1:ALIGN_W];
    end

    // Purpose: name the kind of access carried by the strobe.
    always_comb begin
        if (!stb)    kind = ACC_IDLE;
        else if (we) kind = ACC_WRITE;
        else         kind = ACC_READ;
    end
endmodule

// File: rtl/vault_flags.sv
// Per-word sticky "already read" flags. A flag sets when its word is
// consumed and clears only on reset. Assumes at most one consume per cycle.
module vault_flags #(
    parameter int  N_WORDS = 8,
    localparam int IDX_W   = $clog2(N_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               consume,
    input  logic [IDX_W-1:0]   idx,
    output logic [N_WORDS-1:0] used
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_flag
        // Purpose: set this word's flag on its first consume, hold it after.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  used[g] <= 1'b0;
            else if (consume && (idx == IDX_W'(g)))      used[g] <= 1'b1;
        end
    end

    // R3/R9: a flag never clears while reset is released.
    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((used & $past(used)) == $past(used)));

    // R4: one consume touches at most one word's flag.
    assert_one_flag_per_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(used ^ $past(used)) <= 1));
endmodule

// File: rtl/vault_readout.sv
// Registered read port: returns the selected secret word when a fresh
// read hits an unread word, otherwise zero. Assumes SECRET is packed with
// word 0 in the least significant bits.
module vault_readout
    import vault_pkg::*;
#(
    parameter int  N_WORDS = 8,
    parameter logic [N_WORDS*WORD_W-1:0] SECRET = '0,
    localparam int IDX_W   = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fresh_rd,
    input  logic              already,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] word_tbl [N_WORDS];
    logic [WORD_W-1:0] picked;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        assign word_tbl[g] = SECRET[g*WORD_W +: WORD_W];
    end

    // Purpose: choose the word for the current index.
    always_comb picked = word_tbl[idx];

    // Purpose: register the answer so it is valid the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata <= '0;
        else if (fresh_rd && !already) rdata <= picked;
        else                           rdata <= '0;
    end

    // R8: no new read in a cycle means zero on the next.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fresh_rd |=> (rdata == '0));
endmodule

// File: rtl/secret_vault.sv
// Read-once device secret store. Answers word reads on core select
// CORE_ID; each word is returned once per reset while app_mode is low.
// Assumes rst_n is the power-on reset and strobes last one cycle.
module secret_vault
    import vault_pkg::*;
#(
    parameter int               ADDR_W  = 32,
    parameter int               N_WORDS = 8,
    parameter logic [SEL_W-1:0] CORE_ID = 8'hC2,
    parameter logic [N_WORDS*WORD_W-1:0] SECRET =
        256'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0_13579BDF_2468ACE0_DEADBEEF_A5C3E1F7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_mode,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int IDX_W = $clog2(N_WORDS);

    acc_kind_e          kind;
    logic               in_window;
    logic [IDX_W-1:0]   idx;
    logic               fresh_rd;
    logic [N_WORDS-1:0] used;

    vault_decode #(
        .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .CORE_ID(CORE_ID)
    ) u_decode (
        .stb(bus_stb), .we(bus_we), .addr(bus_addr),
        .kind(kind), .in_window(in_window), .idx(idx)
    );

    // Purpose: a read counts only in loader mode and inside the window.
    always_comb fresh_rd = (kind == ACC_READ) && in_window && !app_mode;

    vault_flags #(.N_WORDS(N_WORDS)) u_flags (
        .clk(clk), .rst_n(rst_n), .consume(fresh_rd), .idx(idx), .used(used)
    );

    vault_readout #(.N_WORDS(N_WORDS), .SECRET(SECRET)) u_readout (
        .clk(clk), .rst_n(rst_n), .fresh_rd(fresh_rd), .already(used[idx]),
        .idx(idx), .rdata(bus_rdata)
    );

    // R5: application-mode reads return zero and consume nothing.
    assert_app_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && app_mode) |=> ((bus_rdata == '0) && $stable(used)));

    // R6: writes return zero and consume nothing.
    assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_we) |=> ((bus_rdata == '0) && $stable(used)));

    // R7: misaligned accesses return zero and consume nothing.
    assert_misaligned_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && (bus_addr[ALIGN_W-1:0] != '0)) |=> ((bus_rdata == '0) && $stable(used)));
endmodule

// File: tb/tb_secret_vault.sv
module tb_secret_vault;
    localparam logic [255:0] KEY =
        256'h11223344_55667788_99AABBCC_DDEEFF00_CAFEF00D_0BADC0DE_76543210_FEDCBA98;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        app_mode = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = 32'h0;
    logic [31:0] bus_rdata;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    started = 0;
    string phase = "R1";

    // Reference model state
    bit          seen [8];
    logic [31:0] exp_q = 32'h0;

    always #4 clk = ~clk;

    secret_vault #(.SECRET(KEY)) dut (
        .clk(clk), .rst_n(rst_n), .app_mode(app_mode), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] key_word(int k);
        return KEY[k*32 +: 32];
    endfunction

    function automatic logic [31:0] waddr(int k);
        return 32'hC200_0000 + 32'(k * 4);
    endfunction

    // Behavioural reference: what the next rdata must be, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q = 32'h0;
            foreach (seen[i]) seen[i] = 1'b0;
        end else begin
            exp_q = 32'h0;
            if (bus_stb && !bus_we && !app_mode && bus_addr[31:24] == 8'hC2
                && bus_addr[23:5] == 19'h0 && bus_addr[1:0] == 2'b00) begin
                if (!seen[bus_addr[4:2]]) begin
                    exp_q = key_word(int'(bus_addr[4:2]));
                    seen[bus_addr[4:2]] = 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (bus_rdata !== exp_q) begin
                n_fail++;
                $display("FAIL %s model compare: actual %h expected %h", phase, bus_rdata, exp_q);
            end
        end
    end

    task automatic check(string req, logic [31:0] expv);
        n_checks++;
        if (bus_rdata !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, bus_rdata, expv);
        end
    endtask

    task automatic access(logic we, logic [31:0] a, string req, logic [31:0] expv);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = we; bus_addr = a;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
        check(req, expv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        started = 1;
        check("R1", 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); check("R1", 32'h0);

        phase = "R2";
        access(1'b0, waddr(0), "R2", key_word(0));
        access(1'b0, waddr(3), "R2", key_word(3));
        access(1'b0, waddr(7), "R2", key_word(7));

        phase = "R3";
        access(1'b0, waddr(3), "R3", 32'h0);
        access(1'b0, waddr(0), "R3", 32'h0);

        phase = "R4";
        access(1'b0, waddr(1), "R4", key_word(1));

        phase = "R5";
        @(negedge clk); app_mode = 1'b1;
        access(1'b0, waddr(2), "R5", 32'h0);
        access(1'b0, waddr(5), "R5", 32'h0);
        access(1'b0, waddr(1), "R5", 32'h0);
        @(negedge clk); app_mode = 1'b0;
        access(1'b0, waddr(2), "R5", key_word(2));

        phase = "R3";
        // back-to-back reads of word 5: first returns it, second returns 0
        @(negedge clk);
        bus_stb = 1'b1; bus_we = 1'b0; bus_addr = waddr(5);
        @(negedge clk);
        check("R3", key_word(5));
        @(negedge clk);
        bus_stb = 1'b0;
        check("R3", 32'h0);

        phase = "R6";
        access(1'b1, waddr(4), "R6", 32'h0);
        @(negedge clk); app_mode = 1'b1;
        access(1'b1, waddr(4), "R6", 32'h0);
        @(negedge clk); app_mode = 1'b0;
        access(1'b0, waddr(4), "R6", key_word(4));

        phase = "R7";
        access(1'b0, waddr(6) + 32'd1, "R7", 32'h0);
        access(1'b0, waddr(6) + 32'd2, "R7", 32'h0);
        access(1'b0, 32'hC200_0020 + 32'h18, "R7", 32'h0);
        access(1'b0, 32'hC300_0018, "R7", 32'h0);
        access(1'b0, 32'hC280_0018, "R7", 32'h0);
        access(1'b0, waddr(6), "R7", key_word(6));

        phase = "R8";
        repeat (4) @(negedge clk);
        check("R8", 32'h0);

        phase = "R9";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); check("R9", 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) access(1'b0, waddr(k), "R9", key_word(k));
        for (int k = 0; k < 8; k++) access(1'b0, waddr(k), "R9", 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule